// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Port

This block is the control-plane front end of a frequency synthesizer with three phase-locked loops: two RF loops, of which only one runs at a time, and one IF loop. A host writes it over a three-wire serial link. The link has a serial clock, a serial data line and an active-low enable. Each frame carries an 18-bit data field and then a 4-bit address. When the enable rises, the frame is committed into one of nine 18-bit configuration registers. The block exports the decoded fields of those registers to the analog loops, the VCOs and the dividers, which are outside the block.

The block remembers which RF divider register was written last, and that decides the active RF loop. It exports the N and R values of the active loop. It also works out the power state of the IF section, the RF section and the reference amplifier. Three things feed that decode: an external power-allow pin, an auto-enable bit and one enable bit per section. A two-bit selector in the main register drives the auxiliary output.

The three serial wires and the power pin pass through a synchronizer of `SYNC_STAGES` flops into the `clk` domain. Each serial clock level and each enable level must therefore last at least `SYNC_STAGES + 1` cycles of `clk`.

Top module: `synth_cfg_port`

## Requirements
- R1: A frame is 22 serial bits. The first bit is data bit 17 and the eighteenth is data bit 0. The last four bits are the address, most significant bit first. Within eight `clk` cycles after `ser_en_n` rises, the 18 data bits are stored in the register at that address.
- R2: While `ser_en_n` is high, rising edges of `ser_clk` shift nothing, so they cannot change what the next commit stores.
- R3: If a frame has more than 22 bits, only the last 22 are used. Earlier leading bits are discarded.
- R4: A commit to address 9 to 15 changes no register and does not change the RF loop selection.
- R5: A commit to address 3 or 6 selects RF1 (`rf2_sel` = 0). A commit to address 4 or 7 selects RF2 (`rf2_sel` = 1). Commits to other addresses leave the selection as it is. `n_rf_act` and `r_rf_act` show the N value (address 3 or 4) and the R value (address 6 or 7) of the selected loop.
- R6: While `pwr_allow` is low, `if_on`, `rf_on` and `ref_on` are 0, whatever the registers hold.
- R7: While `pwr_allow` is high, bit 3 of register 0 set to 1 turns on both sections. Otherwise bit 1 of register 2 enables the IF section and bit 0 of register 2 enables the RF section.
- R8: `ref_on` is 1 exactly when at least one of `if_on` and `rf_on` is 1.
- R9: When register 0 bits 13:12 are 11, `aux_out` follows `lock_fault`. Every other code drives `aux_out` low.
- R10: After reset, all nine registers are zero, RF1 is selected and every output is 0.
- R11: The block decodes these fields. From register 0: bits 11:10 give `if_div`, bit 6 gives `xin_half` and bit 5 gives `if_lowpwr`. From register 1: bits 5:4 give `kp_if`, bits 3:2 give `kp_rf2` and bits 1:0 give `kp_rf1`. The N values are bits 17:0 of register 3 (`n_rf1`), bits 16:0 of register 4 (`n_rf2`) and bits 15:0 of register 5 (`n_if`). The R values are bits 12:0 of registers 6, 7 and 8 (`r_rf1`, `r_rf2`, `r_if`).
- R12: Commits take effect in every power state, including while `pwr_allow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its rising edge |
| ser_data | input | 1 | Serial data line |
| ser_en_n | input | 1 | Serial enable, active low; its rising edge commits the frame |
| pwr_allow | input | 1 | Power-allow pin; low forces every section off |
| lock_fault | input | 1 | Active-high "loop not locked" indicator |
| if_on | output | 1 | IF section enable |
| rf_on | output | 1 | RF section enable |
| ref_on | output | 1 | Reference amplifier enable |
| aux_out | output | 1 | Auxiliary output |
| rf2_sel | output | 1 | 1 when RF2 is the active RF loop |
| if_div | output | 2 | IF output divider code |
| xin_half | output | 1 | Halve the reference input |
| if_lowpwr | output | 1 | IF output buffer low-power mode |
| kp_if | output | 2 | IF phase detector gain code |
| kp_rf2 | output | 2 | RF2 phase detector gain code |
| kp_rf1 | output | 2 | RF1 phase detector gain code |
| n_rf1 | output | 18 | RF1 N divider |
| n_rf2 | output | 17 | RF2 N divider |
| n_if | output | 16 | IF N divider |
| r_rf1 | output | 13 | RF1 R divider |
| r_rf2 | output | 13 | RF2 R divider |
| r_if | output | 13 | IF R divider |
| n_rf_act | output | 18 | N divider of the active RF loop |
| r_rf_act | output | 13 | R divider of the active RF loop |

## Verification
The assertions check four things on every cycle:
- The shifter stays frozen while the enable is high.
- A commit to a reserved address leaves the register bank untouched, and commits to the RF divider addresses move the RF selection correctly.
- The power pin, the auto-enable bit and the auxiliary selector drive the registered outputs correctly.
- The reference enable matches the two section enables.

Only the bench scenarios can show the other behaviours: the bit order within a frame, that extra leading bits are discarded, and that the field positions decode correctly. The bench also replays a frame after stray serial clocks with the enable high, and checks the full power decode table across a series of register writes.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 18;
    localparam int WORD_W   = ADDR_W + DATA_W;
    localparam int NUM_REGS = 9;

    localparam int N_RF1_W = 18;
    localparam int N_RF2_W = 17;
    localparam int N_IF_W  = 16;
    localparam int R_W     = 13;

    localparam logic [ADDR_W-1:0] A_MAIN  = 4'd0;
    localparam logic [ADDR_W-1:0] A_GAIN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PWR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_N_RF1 = 4'd3;
    localparam logic [ADDR_W-1:0] A_N_RF2 = 4'd4;
    localparam logic [ADDR_W-1:0] A_N_IF  = 4'd5;
    localparam logic [ADDR_W-1:0] A_R_RF1 = 4'd6;
    localparam logic [ADDR_W-1:0] A_R_RF2 = 4'd7;
    localparam logic [ADDR_W-1:0] A_R_IF  = 4'd8;

    // bit positions inside the main register
    localparam int MAIN_AUX_LO   = 12;
    localparam int MAIN_IFDIV_LO = 10;
    localparam int MAIN_XHALF    = 6;
    localparam int MAIN_LPWR     = 5;
    localparam int MAIN_AUTO     = 3;
    // bit positions inside the gain register
    localparam int GAIN_IF_LO  = 4;
    localparam int GAIN_RF2_LO = 2;
    localparam int GAIN_RF1_LO = 0;
    // bit positions inside the power register
    localparam int PWR_IF_BIT = 1;
    localparam int PWR_RF_BIT = 0;

    localparam logic [1:0] AUX_LOCK = 2'b11;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int              STAGES  = 2,
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [STAGES-1:0][W-1:0] ch_d, ch_q;

    always_comb begin
        ch_d[0] = in_i;
        for (int i = 1; i < STAGES; i++) begin
            ch_d[i] = ch_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= {STAGES{RST_VAL}};
        else        ch_q <= ch_d;
    end

    assign out_o = ch_q[STAGES-1];
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              sen_hi_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (sclk_rise_i && !sen_hi_i) begin
            sh_d = {sh_q[WORD_W-2:0], sdata_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q;

    // R2
    sen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sen_hi_i |=> $stable(sh_q));

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise_i && !sen_hi_i) |=> (sh_q[0] == $past(sdata_i)));
endmodule

// File: rtl/synth_cfg_bank.sv
module synth_cfg_bank
    import synth_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic [1:0]         aux_sel_o,
    output logic               auto_on_o,
    output logic               pd_if_o,
    output logic               pd_rf_o,
    output logic [1:0]         if_div_o,
    output logic               xin_half_o,
    output logic               if_lowpwr_o,
    output logic [1:0]         kp_if_o,
    output logic [1:0]         kp_rf2_o,
    output logic [1:0]         kp_rf1_o,
    output logic [N_RF1_W-1:0] n_rf1_o,
    output logic [N_RF2_W-1:0] n_rf2_o,
    output logic [N_IF_W-1:0]  n_if_o,
    output logic [R_W-1:0]     r_rf1_o,
    output logic [R_W-1:0]     r_rf2_o,
    output logic [R_W-1:0]     r_if_o,
    output logic [N_RF1_W-1:0] n_act_o,
    output logic [R_W-1:0]     r_act_o,
    output logic               rf2_sel_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] bank;
        logic                            rf2;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    logic [ADDR_W-1:0] cmt_addr;
    logic [DATA_W-1:0] cmt_data;
    logic              addr_ok;

    assign cmt_addr = word_i[ADDR_W-1:0];
    assign cmt_data = word_i[WORD_W-1:ADDR_W];
    assign addr_ok  = (32'(cmt_addr) < NUM_REGS);

    always_comb begin
        st_d = st_q;
        if (commit_i && addr_ok) begin
            st_d.bank[cmt_addr] = cmt_data;
            case (cmt_addr)
                A_N_RF1, A_R_RF1: st_d.rf2 = 1'b0;
                A_N_RF2, A_R_RF2: st_d.rf2 = 1'b1;
                default:          st_d.rf2 = st_q.rf2;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aux_sel_o   = st_q.bank[A_MAIN][MAIN_AUX_LO +: 2];
    assign if_div_o    = st_q.bank[A_MAIN][MAIN_IFDIV_LO +: 2];
    assign xin_half_o  = st_q.bank[A_MAIN][MAIN_XHALF];
    assign if_lowpwr_o = st_q.bank[A_MAIN][MAIN_LPWR];
    assign auto_on_o   = st_q.bank[A_MAIN][MAIN_AUTO];
    assign kp_if_o     = st_q.bank[A_GAIN][GAIN_IF_LO +: 2];
    assign kp_rf2_o    = st_q.bank[A_GAIN][GAIN_RF2_LO +: 2];
    assign kp_rf1_o    = st_q.bank[A_GAIN][GAIN_RF1_LO +: 2];
    assign pd_if_o     = st_q.bank[A_PWR][PWR_IF_BIT];
    assign pd_rf_o     = st_q.bank[A_PWR][PWR_RF_BIT];
    assign n_rf1_o     = st_q.bank[A_N_RF1][N_RF1_W-1:0];
    assign n_rf2_o     = st_q.bank[A_N_RF2][N_RF2_W-1:0];
    assign n_if_o      = st_q.bank[A_N_IF][N_IF_W-1:0];
    assign r_rf1_o     = st_q.bank[A_R_RF1][R_W-1:0];
    assign r_rf2_o     = st_q.bank[A_R_RF2][R_W-1:0];
    assign r_if_o      = st_q.bank[A_R_IF][R_W-1:0];
    assign rf2_sel_o   = st_q.rf2;
    assign n_act_o     = st_q.rf2 ? {{(N_RF1_W-N_RF2_W){1'b0}}, n_rf2_o} : n_rf1_o;
    assign r_act_o     = st_q.rf2 ? r_rf2_o : r_rf1_o;

    // R4
    rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (32'(cmt_addr) >= NUM_REGS)) |=> ($stable(st_q.bank) && $stable(rf2_sel_o)));

    // R5
    rf1_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (cmt_addr == A_N_RF1 || cmt_addr == A_R_RF1)) |=> !rf2_sel_o);

    // R5
    rf2_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (cmt_addr == A_N_RF2 || cmt_addr == A_R_RF2)) |=> rf2_sel_o);

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(rf2_sel_o));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_en_n,
    input  logic               pwr_allow,
    input  logic               lock_fault,
    output logic               if_on,
    output logic               rf_on,
    output logic               ref_on,
    output logic               aux_out,
    output logic               rf2_sel,
    output logic [1:0]         if_div,
    output logic               xin_half,
    output logic               if_lowpwr,
    output logic [1:0]         kp_if,
    output logic [1:0]         kp_rf2,
    output logic [1:0]         kp_rf1,
    output logic [N_RF1_W-1:0] n_rf1,
    output logic [N_RF2_W-1:0] n_rf2,
    output logic [N_IF_W-1:0]  n_if,
    output logic [R_W-1:0]     r_rf1,
    output logic [R_W-1:0]     r_rf2,
    output logic [R_W-1:0]     r_if,
    output logic [N_RF1_W-1:0] n_rf_act,
    output logic [R_W-1:0]     r_rf_act
);
    localparam int            IN_W    = 4;
    localparam logic [IN_W-1:0] IN_RST = 4'b0010; // enable idles high

    typedef struct packed {
        logic sclk_prev;
        logic sen_prev;
        logic if_on;
        logic rf_on;
        logic ref_on;
        logic aux;
    } port_st_t;

    logic [IN_W-1:0]   lvl;
    logic              sclk_lvl, sen_lvl, sdat_lvl, pwr_lvl;
    logic              sclk_rise, commit;
    logic [WORD_W-1:0] word;
    logic [1:0]        aux_sel;
    logic              auto_on, pd_if, pd_rf;
    logic              if_en, rf_en;
    port_st_t          st_d, st_q;

    synth_cfg_sync #(.STAGES(SYNC_STAGES), .W(IN_W), .RST_VAL(IN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({pwr_allow, ser_data, ser_en_n, ser_clk}),
        .out_o (lvl)
    );

    assign sclk_lvl  = lvl[0];
    assign sen_lvl   = lvl[1];
    assign sdat_lvl  = lvl[2];
    assign pwr_lvl   = lvl[3];
    assign sclk_rise = sclk_lvl & ~st_q.sclk_prev;
    assign commit    = sen_lvl & ~st_q.sen_prev;

    synth_cfg_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sen_hi_i    (sen_lvl),
        .sdata_i     (sdat_lvl),
        .word_o      (word)
    );

    synth_cfg_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .word_i      (word),
        .aux_sel_o   (aux_sel),
        .auto_on_o   (auto_on),
        .pd_if_o     (pd_if),
        .pd_rf_o     (pd_rf),
        .if_div_o    (if_div),
        .xin_half_o  (xin_half),
        .if_lowpwr_o (if_lowpwr),
        .kp_if_o     (kp_if),
        .kp_rf2_o    (kp_rf2),
        .kp_rf1_o    (kp_rf1),
        .n_rf1_o     (n_rf1),
        .n_rf2_o     (n_rf2),
        .n_if_o      (n_if),
        .r_rf1_o     (r_rf1),
        .r_rf2_o     (r_rf2),
        .r_if_o      (r_if),
        .n_act_o     (n_rf_act),
        .r_act_o     (r_rf_act),
        .rf2_sel_o   (rf2_sel)
    );

    always_comb begin
        if_en          = pwr_lvl && (auto_on || pd_if);
        rf_en          = pwr_lvl && (auto_on || pd_rf);
        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl;
        st_d.sen_prev  = sen_lvl;
        st_d.if_on     = if_en;
        st_d.rf_on     = rf_en;
        st_d.ref_on    = if_en || rf_en;
        st_d.aux       = (aux_sel == AUX_LOCK) && lock_fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sclk_prev: 1'b0, sen_prev: 1'b1, default: 1'b0};
        else        st_q <= st_d;
    end

    assign if_on   = st_q.if_on;
    assign rf_on   = st_q.rf_on;
    assign ref_on  = st_q.ref_on;
    assign aux_out = st_q.aux;

    // R6
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_lvl |=> (!if_on && !rf_on && !ref_on));

    // R7
    auto_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_lvl && auto_on) |=> (if_on && rf_on));

    // R8
    ref_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_on == (if_on || rf_on));

    // R9
    aux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_sel != AUX_LOCK) |=> !aux_out);
endmodule

// File: tb/synth_cfg_port_test.sv
module synth_cfg_port_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, ser_clk, ser_data, ser_en_n, pwr_allow, lock_fault;
    logic if_on, rf_on, ref_on, aux_out, rf2_sel;
    logic [1:0] if_div, kp_if, kp_rf2, kp_rf1;
    logic xin_half, if_lowpwr;
    logic [17:0] n_rf1, n_rf_act;
    logic [16:0] n_rf2;
    logic [15:0] n_if;
    logic [12:0] r_rf1, r_rf2, r_if, r_rf_act;

    synth_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en_n(ser_en_n), .pwr_allow(pwr_allow), .lock_fault(lock_fault),
        .if_on(if_on), .rf_on(rf_on), .ref_on(ref_on), .aux_out(aux_out),
        .rf2_sel(rf2_sel), .if_div(if_div), .xin_half(xin_half),
        .if_lowpwr(if_lowpwr), .kp_if(kp_if), .kp_rf2(kp_rf2), .kp_rf1(kp_rf1),
        .n_rf1(n_rf1), .n_rf2(n_rf2), .n_if(n_if), .r_rf1(r_rf1),
        .r_rf2(r_rf2), .r_if(r_if), .n_rf_act(n_rf_act), .r_rf_act(r_rf_act)
    );

    localparam int O_IF = 0, O_RF = 1, O_REF = 2, O_AUX = 3, O_SEL = 4;
    localparam int O_NRF1 = 5, O_NRF2 = 6, O_NIF = 7, O_RRF1 = 8, O_RRF2 = 9;
    localparam int O_RIF = 10, O_DIV = 11, O_XH = 12, O_LP = 13, O_KPI = 14;
    localparam int O_KP2 = 15, O_KP1 = 16, O_NACT = 17, O_RACT = 18;

    typedef struct {
        string       req;
        int          sel;
        logic [17:0] exp;
    } item_t;

    item_t sb[$];
    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;

    function automatic logic [17:0] observe(int sel);
        case (sel)
            O_IF:    return 18'(if_on);
            O_RF:    return 18'(rf_on);
            O_REF:   return 18'(ref_on);
            O_AUX:   return 18'(aux_out);
            O_SEL:   return 18'(rf2_sel);
            O_NRF1:  return n_rf1;
            O_NRF2:  return 18'(n_rf2);
            O_NIF:   return 18'(n_if);
            O_RRF1:  return 18'(r_rf1);
            O_RRF2:  return 18'(r_rf2);
            O_RIF:   return 18'(r_if);
            O_DIV:   return 18'(if_div);
            O_XH:    return 18'(xin_half);
            O_LP:    return 18'(if_lowpwr);
            O_KPI:   return 18'(kp_if);
            O_KP2:   return 18'(kp_rf2);
            O_KP1:   return 18'(kp_rf1);
            O_NACT:  return n_rf_act;
            O_RACT:  return 18'(r_rf_act);
            default: return 18'h3ffff;
        endcase
    endfunction

    // driver side: queue an expectation
    task automatic expect_val(string req, int sel, logic [17:0] exp);
        item_t it;
        it.req = req;
        it.sel = sel;
        it.exp = exp;
        sb.push_back(it);
    endtask

    // monitor side: pop and compare
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (observe(it.sel) !== it.exp) begin
                failures++;
                $display("FAIL %s (output %0d) actual=%h expected=%h",
                         it.req, it.sel, observe(it.sel), it.exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        tick(3);
    endtask

    task automatic put_bit(logic b);
        ser_data = b;
        ser_clk  = 1'b0;
        tick(3);
        ser_clk  = 1'b1;
        tick(3);
        ser_clk  = 1'b0;
    endtask

    task automatic put_word(logic [21:0] w);
        for (int i = 21; i >= 0; i--) put_bit(w[i]);
    endtask

    task automatic frame(logic [3:0] a, logic [17:0] d, int lead);
        ser_en_n = 1'b0;
        tick(3);
        for (int i = 0; i < lead; i++) put_bit(1'b1);
        put_word({d, a});
        tick(3);
        ser_en_n = 1'b1;
        tick(8);
    endtask

    task automatic set_pin(logic v);
        pwr_allow = v;
        tick(8);
    endtask

    initial begin
        rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_en_n = 1'b1;
        pwr_allow = 1'b0; lock_fault = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R10 reset state
        expect_val("R10 if_on", O_IF, 0);
        expect_val("R10 rf_on", O_RF, 0);
        expect_val("R10 ref_on", O_REF, 0);
        expect_val("R10 aux", O_AUX, 0);
        expect_val("R10 rf1 active", O_SEL, 0);
        expect_val("R10 n_rf1", O_NRF1, 0);
        expect_val("R10 r_if", O_RIF, 0);
        settle();

        // R1 / R12: writes while the power pin is low
        frame(4'd3, 18'h2ABCD, 0);
        expect_val("R1 R12 n_rf1", O_NRF1, 18'h2ABCD);
        expect_val("R5 rf1 after N", O_SEL, 0);
        expect_val("R5 n_act rf1", O_NACT, 18'h2ABCD);
        settle();
        frame(4'd4, 18'h12345, 0);
        expect_val("R11 n_rf2", O_NRF2, 18'h12345);
        expect_val("R5 rf2 after N", O_SEL, 1);
        expect_val("R5 n_act rf2", O_NACT, 18'h12345);
        settle();
        frame(4'd5, 18'h0BEEF, 0);
        expect_val("R11 n_if", O_NIF, 18'h0BEEF);
        expect_val("R5 sel held", O_SEL, 1);
        settle();
        frame(4'd6, 18'h01ABC, 0);
        expect_val("R11 r_rf1", O_RRF1, 18'h01ABC);
        expect_val("R5 rf1 after R", O_SEL, 0);
        expect_val("R5 r_act rf1", O_RACT, 18'h01ABC);
        settle();
        frame(4'd7, 18'h00123, 0);
        expect_val("R11 r_rf2", O_RRF2, 18'h00123);
        expect_val("R5 rf2 after R", O_SEL, 1);
        expect_val("R5 r_act rf2", O_RACT, 18'h00123);
        settle();
        frame(4'd8, 18'h01FFF, 0);
        expect_val("R11 r_if", O_RIF, 18'h01FFF);
        settle();
        frame(4'd1, 18'h00027, 0);
        expect_val("R11 kp_if", O_KPI, 2);
        expect_val("R11 kp_rf2", O_KP2, 1);
        expect_val("R11 kp_rf1", O_KP1, 3);
        settle();
        frame(4'd0, 18'h03B42, 0);
        expect_val("R11 if_div", O_DIV, 2);
        expect_val("R11 xin_half", O_XH, 1);
        expect_val("R11 if_lowpwr", O_LP, 0);
        settle();

        // R6: both enables set but the pin is low
        frame(4'd2, 18'h00003, 0);
        expect_val("R6 if off", O_IF, 0);
        expect_val("R6 rf off", O_RF, 0);
        expect_val("R6 ref off", O_REF, 0);
        settle();

        // R7 / R8 decode table
        set_pin(1'b1);
        expect_val("R7 if on", O_IF, 1);
        expect_val("R7 rf on", O_RF, 1);
        expect_val("R8 ref on", O_REF, 1);
        settle();
        frame(4'd2, 18'h00001, 0);
        expect_val("R7 rf only if", O_IF, 0);
        expect_val("R7 rf only rf", O_RF, 1);
        expect_val("R8 rf only ref", O_REF, 1);
        settle();
        frame(4'd2, 18'h00002, 0);
        expect_val("R7 if only if", O_IF, 1);
        expect_val("R7 if only rf", O_RF, 0);
        expect_val("R8 if only ref", O_REF, 1);
        settle();
        frame(4'd2, 18'h00000, 0);
        expect_val("R7 none if", O_IF, 0);
        expect_val("R7 none rf", O_RF, 0);
        expect_val("R8 none ref", O_REF, 0);
        settle();
        frame(4'd0, 18'h03B4A, 0);
        expect_val("R7 auto if", O_IF, 1);
        expect_val("R7 auto rf", O_RF, 1);
        settle();
        set_pin(1'b0);
        expect_val("R6 pin over auto if", O_IF, 0);
        expect_val("R6 pin over auto rf", O_RF, 0);
        expect_val("R6 pin over auto ref", O_REF, 0);
        settle();
        set_pin(1'b1);

        // R9 auxiliary output
        lock_fault = 1'b1;
        tick(4);
        expect_val("R9 aux lock high", O_AUX, 1);
        settle();
        lock_fault = 1'b0;
        tick(4);
        expect_val("R9 aux lock low", O_AUX, 0);
        settle();
        frame(4'd0, 18'h01B6A, 0);
        lock_fault = 1'b1;
        tick(4);
        expect_val("R9 aux forced low", O_AUX, 0);
        expect_val("R11 if_lowpwr set", O_LP, 1);
        settle();
        lock_fault = 1'b0;

        // R4 reserved addresses
        frame(4'd9, 18'h3FFFF, 0);
        frame(4'd15, 18'h3FFFF, 0);
        expect_val("R4 n_rf1 kept", O_NRF1, 18'h2ABCD);
        expect_val("R4 r_if kept", O_RIF, 18'h01FFF);
        expect_val("R4 sel kept", O_SEL, 1);
        expect_val("R4 if_div kept", O_DIV, 2);
        expect_val("R4 kp_rf1 kept", O_KP1, 3);
        settle();

        // R2 stray clocks with enable high, then an empty frame
        frame(4'd4, 18'h00777, 0);
        expect_val("R2 setup n_rf2", O_NRF2, 18'h00777);
        settle();
        put_word({18'h15555, 4'd3});
        ser_en_n = 1'b0;
        tick(4);
        ser_en_n = 1'b1;
        tick(8);
        expect_val("R2 n_rf1 untouched", O_NRF1, 18'h2ABCD);
        expect_val("R2 rf2 still active", O_SEL, 1);
        expect_val("R2 n_rf2 recommitted", O_NRF2, 18'h00777);
        settle();

        // R3 leading bits discarded
        frame(4'd5, 18'h01234, 5);
        expect_val("R3 n_if", O_NIF, 18'h01234);
        settle();

        tick(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule